// File: doc/BRIEF.md
# Prescaled ADC Conversion Controller

This block is the digital front-end of an eight-input successive-approximation converter that software reaches over a 32-bit register bus. Software picks an input channel and sets a clock divider and a result width. It then sets a start bit in the control word. The block paces the conversion with the divided clock and drives the channel select toward the analog mux. When the last step ends, it captures the converter's raw code and trims it to the chosen width. It keeps the trimmed value in a data register and raises a level interrupt that stays high until software clears it.

A standby bit parks the converter. While it is set, start requests are refused, and any conversion in progress is dropped without an interrupt. The divider setting and the width are copied when a conversion begins, so software may rewrite the control word while a conversion runs. The analog part is outside the block: the raw code arrives on an input port.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Register offsets are: control 0x00, delay 0x08 (16-bit read/write storage), result 0x0C (read-only), interrupt clear 0x18 and channel select 0x1C. A read strobe returns the addressed value on `bus_rdata` after the next clock edge, and that value holds until the next read. Any unmapped offset reads as 0.
- R2: Control word fields: bit 0 start, bit 2 standby, bits 13:6 divider value, bit 14 divider enable, bit 16 wide (12-bit) result. After reset the control word reads 0x00014C40: divider 49, divider enabled, wide result, start 0, standby 0.
- R3: The channel select register keeps the low 3 bits of the written value (channels 0 to 7). It drives `adc_sel` one cycle after the write and reads back the same value.
- R4: Writing the control word with bit 0 set, while the block is idle and the written standby bit is 0, sets start. Start reads back as 1 only up to the following clock edge. `adc_busy` rises at that edge, and start then reads 0.
- R5: A conversion lasts (5 + W) × (D + 1) clock cycles while the divider is enabled, and (5 + W) cycles while it is disabled. W is 12 or 10 and D is the divider value. The interrupt becomes visible N + 1 edges after the edge that wrote start.
- R6: The result register holds the input code masked with 0xFFF when the wide bit was set at start, and masked with 0x3FF otherwise.
- R7: At the end of a conversion the result register updates and `adc_irq` rises on the same edge. `adc_irq` then stays high until it is cleared.
- R8: Any write to offset 0x18 clears `adc_irq`, whatever data is written. If the clear write falls on the same edge as a completion, the interrupt stays set.
- R9: The standby bit drives `adc_standby`. A start written together with standby set is refused. Setting standby during a conversion ends it within two edges, with no interrupt and no change to the result.
- R10: A start written while a conversion runs is ignored. The running conversion ends on its original schedule, and no second conversion follows it.
- R11: The divider setting and the result width are captured at the start of a conversion. Rewriting them during the conversion changes neither its length nor its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| conv_code | input | 12 | Raw code from the converter |
| adc_sel | output | 3 | Channel select to the analog mux |
| adc_busy | output | 1 | Conversion in progress |
| adc_standby | output | 1 | Converter parked in low-power idle |
| adc_irq | output | 1 | Conversion-done interrupt (level) |

## Verification
The main conversion path is run with four settings:
- Default divider with the wide result, using code 0xABC. This separates the divided timing from undivided timing.
- A small divider with the narrow result, using code 0xFFF. This exposes any masking error.
- Divider disabled, so any off-by-one in the cycle count shows up directly.
- A conversion whose divider and width are rewritten midway. This separates values captured at start from live register values.

The corner cases are:
- A clear write placed on the completion edge.
- A second start during a busy period.
- A start written together with standby.
- A standby abort midway through a long conversion, which tells a silent abort apart from a late completion.

A behavioural model steps alongside the design on every clock and compares all outputs.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [REG_AW-1:0] OFS_DLY  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_DATA = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_CLR  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_MUX  = 8'h1C;

  localparam int BIT_GO     = 0;
  localparam int BIT_STBY   = 2;
  localparam int BIT_DIV_LO = 6;
  localparam int BIT_DIV_EN = 14;
  localparam int BIT_WIDE   = 16;

  localparam int DIV_INIT_VAL = 49;
endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int PRESC_W      = 8,
  parameter int DATA_W       = 12,
  parameter int NARROW_W     = 10,
  parameter int SAMPLE_TICKS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               standby,
  input  logic               div_en,
  input  logic [PRESC_W-1:0] div_val,
  input  logic               wide,
  input  logic [DATA_W-1:0]  code,
  output logic               busy,
  output logic               fin,
  output logic [DATA_W-1:0]  fin_code
);
  localparam int MAX_LEN = SAMPLE_TICKS + DATA_W;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_WIDE   = LEN_W'(SAMPLE_TICKS + DATA_W);
  localparam logic [LEN_W-1:0] LEN_NARROW = LEN_W'(SAMPLE_TICKS + NARROW_W);

  logic [PRESC_W-1:0] div_cnt, div_lim;
  logic [LEN_W-1:0]   tick_cnt, len_lat;
  logic               wide_lat;
  logic               tick, last;
  logic [DATA_W-1:0]  narrow_code;

  generate
    if (NARROW_W < DATA_W) begin : g_trim
      assign narrow_code = {{(DATA_W-NARROW_W){1'b0}}, code[NARROW_W-1:0]};
    end else begin : g_full
      assign narrow_code = code;
    end
  endgenerate

  assign tick     = busy && (div_cnt == div_lim);
  assign last     = (tick_cnt == len_lat - LEN_W'(1));
  assign fin      = tick && last && !standby;
  assign fin_code = wide_lat ? code : narrow_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      div_cnt  <= '0;
      div_lim  <= '0;
      tick_cnt <= '0;
      len_lat  <= '0;
      wide_lat <= 1'b0;
    end else if (standby) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        div_lim  <= div_en ? div_val : '0;
        len_lat  <= wide ? LEN_WIDE : LEN_NARROW;
        wide_lat <= wide;
        div_cnt  <= '0;
        tick_cnt <= '0;
      end
    end else if (tick) begin
      div_cnt <= '0;
      if (last) busy <= 1'b0;
      else      tick_cnt <= tick_cnt + LEN_W'(1);
    end else begin
      div_cnt <= div_cnt + PRESC_W'(1);
    end
  end

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst) standby |=> !busy); // R9
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (tick_cnt < len_lat)); // R5
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (div_cnt <= div_lim)); // R5
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int DATA_W  = 12,
  parameter int CH_W    = 3,
  parameter int DLY_W   = 16,
  parameter int BUS_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  input  logic               seq_busy,
  input  logic               fin,
  input  logic [DATA_W-1:0]  fin_code,
  output logic               standby,
  output logic               div_en,
  output logic [PRESC_W-1:0] div_val,
  output logic               wide,
  output logic               start_q,
  output logic [CH_W-1:0]    ch_sel,
  output logic               irq
);
  localparam logic [PRESC_W-1:0] DIV_INIT = PRESC_W'(DIV_INIT_VAL);

  logic              wr_ctrl, wr_dly, wr_clr, wr_mux;
  logic [DLY_W-1:0]  dly_q;
  logic [DATA_W-1:0] data_q;
  logic [BUS_W-1:0]  ctrl_word;

  assign wr_ctrl = wr_en && (addr == OFS_CTRL);
  assign wr_dly  = wr_en && (addr == OFS_DLY);
  assign wr_clr  = wr_en && (addr == OFS_CLR);
  assign wr_mux  = wr_en && (addr == OFS_MUX);

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[BIT_GO]                  = start_q;
    ctrl_word[BIT_STBY]                = standby;
    ctrl_word[BIT_DIV_LO +: PRESC_W]   = div_val;
    ctrl_word[BIT_DIV_EN]              = div_en;
    ctrl_word[BIT_WIDE]                = wide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      standby <= 1'b0;
      div_en  <= 1'b1;
      div_val <= DIV_INIT;
      wide    <= 1'b1;
    end else if (wr_ctrl) begin
      standby <= wdata[BIT_STBY];
      div_en  <= wdata[BIT_DIV_EN];
      div_val <= wdata[BIT_DIV_LO +: PRESC_W];
      wide    <= wdata[BIT_WIDE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      start_q <= 1'b0;
    else if (start_q)
      start_q <= 1'b0;
    else if (wr_ctrl && wdata[BIT_GO] && !wdata[BIT_STBY] && !seq_busy)
      start_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_sel <= '0;
      dly_q  <= '0;
    end else begin
      if (wr_mux) ch_sel <= wdata[CH_W-1:0];
      if (wr_dly) dly_q  <= wdata[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (fin) data_q <= fin_code;
      if (fin)         irq <= 1'b1;
      else if (wr_clr) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        OFS_CTRL: rdata <= ctrl_word;
        OFS_DLY:  rdata <= BUS_W'(dly_q);
        OFS_DATA: rdata <= BUS_W'(data_q);
        OFS_MUX:  rdata <= BUS_W'(ch_sel);
        default:  rdata <= '0;
      endcase
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst) start_q |=> !start_q); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) (irq && !wr_clr) |=> irq); // R7
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (rst) fin |=> irq); // R8
  AST_GO_BLOCKED: assert property (@(posedge clk) disable iff (rst) (wr_ctrl && wdata[BIT_STBY]) |=> !start_q); // R9
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int PRESC_W      = 8,
  parameter int DATA_W       = 12,
  parameter int NARROW_W     = 10,
  parameter int SAMPLE_TICKS = 5,
  parameter int CH_W         = 3,
  parameter int DLY_W        = 16,
  parameter int BUS_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [DATA_W-1:0] conv_code,
  output logic [CH_W-1:0]   adc_sel,
  output logic              adc_busy,
  output logic              adc_standby,
  output logic              adc_irq
);
  logic               standby, div_en, wide, start_q, busy, fin;
  logic [PRESC_W-1:0] div_val;
  logic [DATA_W-1:0]  fin_code;

  sar_adc_regs #(
    .PRESC_W(PRESC_W), .DATA_W(DATA_W), .CH_W(CH_W), .DLY_W(DLY_W), .BUS_W(BUS_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .seq_busy(busy), .fin(fin),
    .fin_code(fin_code), .standby(standby), .div_en(div_en), .div_val(div_val),
    .wide(wide), .start_q(start_q), .ch_sel(adc_sel), .irq(adc_irq)
  );

  sar_adc_seq #(
    .PRESC_W(PRESC_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .SAMPLE_TICKS(SAMPLE_TICKS)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start_q), .standby(standby), .div_en(div_en),
    .div_val(div_val), .wide(wide), .code(conv_code), .busy(busy), .fin(fin),
    .fin_code(fin_code)
  );

  assign adc_busy    = busy;
  assign adc_standby = standby;
endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] conv_code = '0;
  logic [2:0]  adc_sel;
  logic        adc_busy, adc_standby, adc_irq;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_code(conv_code),
    .adc_sel(adc_sel), .adc_busy(adc_busy), .adc_standby(adc_standby), .adc_irq(adc_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference model
  bit m_stby, m_en, m_wide, m_go, m_busy, m_cwide, m_irq;
  int m_div, m_rem, m_ch, m_dly, m_data;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_ctrl();
    return (32'(m_wide) << 16) | (32'(m_en) << 14) | (32'(m_div) << 6) | (32'(m_stby) << 2) | 32'(m_go);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stby = 0; m_en = 1; m_wide = 1; m_div = 49; m_go = 0; m_busy = 0;
      m_rem = 0; m_cwide = 0; m_irq = 0; m_ch = 0; m_dly = 0; m_data = 0; m_rdata = '0;
    end else begin
      bit fin, n_busy, n_go, n_irq;
      int n_rem, n_data;
      logic [31:0] n_rdata;
      fin = 0; n_busy = m_busy; n_rem = m_rem; n_data = m_data; n_irq = m_irq;
      if (m_stby) n_busy = 0;
      else if (m_busy) begin
        n_rem = m_rem - 1;
        if (n_rem == 0) begin fin = 1; n_busy = 0; end
      end else if (m_go) begin
        n_busy = 1;
        n_rem  = (5 + (m_wide ? 12 : 10)) * ((m_en ? m_div : 0) + 1);
        m_cwide = m_wide;
      end
      n_go = 0;
      if (!m_go && bus_wr && bus_addr == 8'h00 && bus_wdata[0] && !bus_wdata[2] && !m_busy) n_go = 1;
      if (fin) begin
        n_data = m_cwide ? int'(conv_code) : int'(conv_code & 12'h3FF);
        n_irq = 1;
      end else if (bus_wr && bus_addr == 8'h18) n_irq = 0;
      n_rdata = m_rdata;
      if (bus_rd) begin
        case (bus_addr)
          8'h00: n_rdata = m_ctrl();
          8'h08: n_rdata = 32'(m_dly);
          8'h0C: n_rdata = 32'(m_data);
          8'h1C: n_rdata = 32'(m_ch);
          default: n_rdata = '0;
        endcase
      end
      if (bus_wr && bus_addr == 8'h00) begin
        m_stby = bus_wdata[2]; m_en = bus_wdata[14]; m_wide = bus_wdata[16]; m_div = int'(bus_wdata[13:6]);
      end
      if (bus_wr && bus_addr == 8'h1C) m_ch = int'(bus_wdata[2:0]);
      if (bus_wr && bus_addr == 8'h08) m_dly = int'(bus_wdata[15:0]);
      m_busy = n_busy; m_rem = n_rem; m_go = n_go; m_irq = n_irq; m_data = n_data; m_rdata = n_rdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 model irq", 32'(adc_irq), 32'(m_irq));
      chk("R4 model busy", 32'(adc_busy), 32'(m_busy));
      chk("R9 model standby", 32'(adc_standby), 32'(m_stby));
      chk("R3 model sel", 32'(adc_sel), 32'(m_ch));
      chk("R1 model rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0; v = bus_rdata;
  endtask

  task automatic wait_irq(output int cycles, input int t0);
    while (!adc_irq && cyc < WATCHDOG) @(negedge clk);
    cycles = cyc - t0;
  endtask

  initial begin
    logic [31:0] v;
    int t0, n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R7 reset irq", 32'(adc_irq), 0);
    chk("R4 reset busy", 32'(adc_busy), 0);
    rd(8'h00, v); chk("R2 reset ctrl", v, 32'h0001_4C40);
    rd(8'h0C, v); chk("R1 reset data", v, 0);
    rd(8'h04, v); chk("R1 unmapped", v, 0);

    // channel select and delay storage
    wr(8'h1C, 32'hF); chk("R3 sel masked", 32'(adc_sel), 7);
    rd(8'h1C, v); chk("R3 sel readback", v, 7);
    wr(8'h1C, 32'h3);
    wr(8'h08, 32'h1234_ABCD); rd(8'h08, v); chk("R1 delay rw", v, 32'hABCD);

    // default settings, wide result
    conv_code = 12'hABC;
    rd(8'h00, v); wr(8'h00, v | 32'h1); t0 = cyc;
    rd(8'h00, v); chk("R4 start visible", v & 1, 1);
    rd(8'h00, v); chk("R4 start self clears", v & 1, 0);
    chk("R4 busy", 32'(adc_busy), 1);
    wait_irq(n, t0); chk("R5 divided length", n, 17 * 50 + 1);
    rd(8'h0C, v); chk("R6 wide mask", v, 32'hABC);
    repeat (5) @(negedge clk); chk("R7 irq held", 32'(adc_irq), 1);
    wr(8'h18, 32'h0); chk("R8 clear", 32'(adc_irq), 0);

    // narrow result, divider 2
    conv_code = 12'hFFF;
    wr(8'h00, (32'h1 << 14) | (32'd2 << 6) | 32'h1); t0 = cyc;
    wait_irq(n, t0); chk("R5 narrow length", n, 15 * 3 + 1);
    rd(8'h0C, v); chk("R6 narrow mask", v, 32'h3FF);
    wr(8'h18, 32'hDEAD);

    // divider disabled, clear on completion edge
    conv_code = 12'h5A5;
    wr(8'h00, (32'h1 << 16) | 32'h1);
    repeat (17) @(negedge clk);
    wr(8'h18, 32'h1);
    chk("R8 completion wins", 32'(adc_irq), 1);
    rd(8'h0C, v); chk("R5 undivided result", v, 32'h5A5);
    wr(8'h18, 32'h1);

    // settings captured at start
    conv_code = 12'hFFF;
    wr(8'h00, (32'h1 << 14) | (32'd3 << 6) | 32'h1); t0 = cyc;
    repeat (10) @(negedge clk);
    wr(8'h00, (32'h1 << 16) | (32'h1 << 14) | (32'd9 << 6));
    wait_irq(n, t0); chk("R11 length captured", n, 15 * 4 + 1);
    rd(8'h0C, v); chk("R11 mask captured", v, 32'h3FF);
    wr(8'h18, 32'h1);

    // restart while busy
    conv_code = 12'h123;
    wr(8'h00, (32'h1 << 16) | 32'h1); t0 = cyc;
    repeat (5) @(negedge clk);
    wr(8'h00, (32'h1 << 16) | 32'h1);
    wait_irq(n, t0); chk("R10 restart ignored", n, 18);
    repeat (30) @(negedge clk); chk("R10 no second run", 32'(adc_busy), 0);
    wr(8'h18, 32'h1);

    // standby
    wr(8'h00, (32'h1 << 16) | (32'h1 << 2) | 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 standby out", 32'(adc_standby), 1);
    chk("R9 start refused", 32'(adc_busy), 0);
    rd(8'h00, v); chk("R9 start bit clear", v & 1, 0);
    conv_code = 12'h777;
    wr(8'h00, 32'h0001_4C41);
    repeat (100) @(negedge clk); chk("R9 running", 32'(adc_busy), 1);
    wr(8'h00, 32'h0001_4C44);
    @(negedge clk); chk("R9 abort", 32'(adc_busy), 0);
    repeat (1000) @(negedge clk); chk("R9 no irq after abort", 32'(adc_irq), 0);
    rd(8'h0C, v); chk("R9 result untouched", v, 32'h123);
    wr(8'h00, 32'h0001_4C40);
    repeat (3) @(negedge clk); chk("R9 idle after wake", 32'(adc_busy), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R5 actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule